// File: doc/BRIEF.md
# Registered ROM with Dual Output Enables

This block is a read-only lookup table of 1024 words, each 8 bits wide. A pipeline register sits on its output. On each rising clock edge where the active-low clocked enable is low, the word at the present address is taken into the output register. That word stays there until a later load. Two enables control whether the output is driven. The first is sampled on the clock and held in an internal flag. The second acts at once, with no clock involved.

The output pins are modelled as an 8-bit data bus plus a drive flag. Whenever the drive flag is low, the data bus reads as zero, which stands in for a released bus.

An active-low initialize input loads a parameterized initialize word into the output register immediately. This load does not wait for the clock. The table contents are computed from a seed parameter, so no external file is needed.

Top module: `regrom_dual_en`

## Requirements
- R1: The table has 2^ADDR_W words (1024 by default) of DATA_W bits (8 by default). The word at address a is the low DATA_W bits of ((a*157 + (a>>4)) XOR SEED), where SEED defaults to 8'h5A.
- R2: While rst is high at a clock edge, the enable flag moves to its off state. After reset, drive is 0 and dout is 0.
- R3: When init_n is high and sen_n is low at a rising edge, the output register takes the word at addr from that edge. If driven, that word appears on dout after the edge.
- R4: drive is 1 only when the enable flag is on and aen_n is low. Raising aen_n turns drive off at once, with no clock needed. When drive is 0, dout reads 0.
- R5: When sen_n is high at a rising edge, drive turns off from that edge, whatever aen_n is. When sen_n is low at a later edge, drive returns if aen_n is low.
- R6: Between rising edges, changes on addr and sen_n leave dout and drive unchanged. An edge with sen_n high leaves the output register unchanged.
- R7: While init_n is low, the output register holds INIT_WORD. The load takes effect at once, without a clock, and it overrides any clocked load. init_n does not change the enable flag.
- R8: While drive is 0, the initialize word does not appear on dout. It appears once the normal enable conditions are met.
- R9: INIT_WORD defaults to all zeros, so initialize acts as a clear. With INIT_WORD set to all ones, it acts as a preset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset of the enable flag |
| addr | input | ADDR_W | Read address, sampled on the rising edge |
| sen_n | input | 1 | Clocked enable, active low |
| aen_n | input | 1 | Immediate enable, active low |
| init_n | input | 1 | Asynchronous initialize, active low |
| dout | output | DATA_W | Output word; zero when not driven |
| drive | output | 1 | High when the output is driven |

## Verification
The hold check on the output register assumes one thing about init_n: if it is high at two successive rising edges, it stays high between them. This means every initialize pulse spans at least one rising edge. The bench always asserts init_n at a falling edge or mid-cycle and keeps it low across an edge before releasing it. The randomized part holds init_n high throughout. Address, sen_n and aen_n change only at falling edges or mid-cycle, never at a rising edge.

// File: rtl/rom_pkg.sv
package rom_pkg;

  typedef enum logic {
    DRV_ON  = 1'b0,
    DRV_OFF = 1'b1
  } drv_state_e;

  function automatic logic [31:0] rom_word(input logic [31:0] a, input logic [31:0] seed);
    logic [31:0] mix;
    mix = (a * 32'd157) + (a >> 4);
    return mix ^ seed;
  endfunction

endpackage

// File: rtl/rom_core.sv
module rom_core #(
  parameter int                 ADDR_W    = 10,
  parameter int                 DATA_W    = 8,
  parameter logic [DATA_W-1:0]  SEED      = 8'h5A,
  parameter logic [DATA_W-1:0]  INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              load_en_n,
  input  logic              init_n,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(rom_pkg::rom_word(32'(i), 32'(SEED)));
    end
  end

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      q <= INIT_WORD;
    end else if (!load_en_n) begin
      q <= mem[addr];
    end
  end

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (load_en_n && init_n) ##1 init_n |-> $stable(q)); // R6

  AST_INIT_WINS: assert property (@(posedge clk) disable iff (rst)
    !init_n |-> (q == INIT_WORD)); // R7

endmodule

// File: rtl/sen_flag.sv
module sen_flag (
  input  logic                clk,
  input  logic                rst,
  input  logic                sen_n,
  output rom_pkg::drv_state_e state
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state <= rom_pkg::DRV_OFF;
    end else begin
      state <= sen_n ? rom_pkg::DRV_OFF : rom_pkg::DRV_ON;
    end
  end
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int DATA_W = 8
) (
  input  rom_pkg::drv_state_e state,
  input  logic                aen_n,
  input  logic [DATA_W-1:0]   q,
  output logic [DATA_W-1:0]   dout,
  output logic                drive
);
  always_comb begin
    drive = (state == rom_pkg::DRV_ON) && !aen_n;
    dout  = drive ? q : '0;
  end
endmodule

// File: rtl/regrom_dual_en.sv
module regrom_dual_en #(
  parameter int                ADDR_W    = 10,
  parameter int                DATA_W    = 8,
  parameter logic [DATA_W-1:0] SEED      = 8'h5A,
  parameter logic [DATA_W-1:0] INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              sen_n,
  input  logic              aen_n,
  input  logic              init_n,
  output logic [DATA_W-1:0] dout,
  output logic              drive
);
  logic [DATA_W-1:0]   q;
  rom_pkg::drv_state_e state;

  rom_core #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEED(SEED), .INIT_WORD(INIT_WORD)
  ) u_core (
    .clk(clk), .rst(rst), .addr(addr), .load_en_n(sen_n), .init_n(init_n), .q(q)
  );

  sen_flag u_flag (
    .clk(clk), .rst(rst), .sen_n(sen_n), .state(state)
  );

  out_gate #(.DATA_W(DATA_W)) u_gate (
    .state(state), .aen_n(aen_n), .q(q), .dout(dout), .drive(drive)
  );

  AST_AEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    aen_n |-> !drive); // R4

  AST_SEN_TURNS_OFF: assert property (@(posedge clk) disable iff (rst)
    sen_n |=> !drive); // R5

  AST_UNDRIVEN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !drive |-> (dout == '0)); // R8

  AST_SEN_ON_RESTORES: assert property (@(posedge clk) disable iff (rst)
    (!sen_n && !aen_n) ##1 !aen_n |-> drive); // R5

endmodule

// File: tb/tb_regrom_dual_en.sv
module tb_regrom_dual_en;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;
  localparam logic [7:0] SEED = 8'h5A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic sen_n = 1'b1, aen_n = 1'b0, init_n = 1'b1;
  logic [DATA_W-1:0] dout, dout_p;
  logic drive, drive_p;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q, exp_qp;
  logic       exp_off;

  always #(CLK_PERIOD/2) clk = ~clk;

  regrom_dual_en dut (
    .clk(clk), .rst(rst), .addr(addr), .sen_n(sen_n), .aen_n(aen_n),
    .init_n(init_n), .dout(dout), .drive(drive)
  );

  regrom_dual_en #(.INIT_WORD(8'hFF)) dut_preset (
    .clk(clk), .rst(rst), .addr(addr), .sen_n(sen_n), .aen_n(aen_n),
    .init_n(init_n), .dout(dout_p), .drive(drive_p)
  );

  function automatic logic [7:0] word_of(input int a);
    int v;
    v = (a * 157 + (a >> 4)) & 32'hFF;
    return 8'(v) ^ SEED;
  endfunction

  task automatic check(input string req, input logic [7:0] act_d, input logic [7:0] exp_d,
                       input logic act_v, input logic exp_v);
    checks++;
    if (act_d !== exp_d || act_v !== exp_v) begin
      errors++;
      $display("FAIL %s: dout=%h drive=%b expected dout=%h drive=%b", req, act_d, act_v, exp_d, exp_v);
    end
  endtask

  task automatic check_both(input string req);
    logic v;
    v = !exp_off && !aen_n;
    check(req, dout, v ? exp_q : 8'h00, drive, v);
    check(req, dout_p, v ? exp_qp : 8'h00, drive_p, v);
  endtask

  task automatic step(input int a, input logic s, input logic e);
    @(negedge clk);
    addr = ADDR_W'(a); sen_n = s; aen_n = e;
    @(posedge clk);
    if (!init_n) begin exp_q = 8'h00; exp_qp = 8'hFF; end
    else if (!s) begin exp_q = word_of(a); exp_qp = word_of(a); end
    exp_off = s;
    #2;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_q = 8'h00; exp_qp = 8'h00; exp_off = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R2 reset", dout, 8'h00, drive, 1'b0);
    @(negedge clk); rst = 1'b0;

    // R3 read path, boundary addresses
    step(0, 1'b0, 1'b0);    check_both("R3 addr 0 / R1");
    step(1023, 1'b0, 1'b0); check_both("R3 addr 1023 / R1");

    // R6 mid-cycle changes have no effect
    step(517, 1'b0, 1'b0);
    #1 addr = 10'd3; sen_n = 1'b1;
    #1 check("R6 mid-cycle", dout, word_of(517), drive, 1'b1);

    // R5 sen high at edge turns off regardless of aen
    step(3, 1'b1, 1'b0);    check_both("R5 off at edge");
    step(8, 1'b1, 1'b0);    check_both("R6 reg hold while off");
    step(8, 1'b0, 1'b0);    check_both("R5 back on");

    // R4 immediate enable
    #1 aen_n = 1'b1;
    #1 check("R4 aen off immediate", dout, 8'h00, drive, 1'b0);
    aen_n = 1'b0;
    #1 check("R4 aen on immediate", dout, word_of(8), drive, 1'b1);

    // R7/R9 immediate init while driven
    init_n = 1'b0;
    #1 check("R7 R9 clear immediate", dout, 8'h00, drive, 1'b1);
    check("R9 preset immediate", dout_p, 8'hFF, drive_p, 1'b1);
    exp_q = 8'h00; exp_qp = 8'hFF;
    step(77, 1'b0, 1'b0);   check_both("R7 init overrides load");
    @(negedge clk); init_n = 1'b1;
    step(77, 1'b0, 1'b0);   check_both("R3 load after init release");

    // R8 init hidden while not driven
    step(90, 1'b1, 1'b0);
    @(negedge clk); init_n = 1'b0;
    #1 check("R8 init hidden", dout_p, 8'h00, drive_p, 1'b0);
    exp_q = 8'h00; exp_qp = 8'hFF;
    step(91, 1'b0, 1'b0);   check_both("R8 init shown once enabled / R7 flag kept");
    @(negedge clk); init_n = 1'b1;

    // randomized reads with directed checks interleaved
    for (int i = 0; i < 400; i++) begin
      int a;
      logic s, e;
      a = int'($urandom_range(1023, 0));
      s = ($urandom_range(9, 0) < 3);
      e = ($urandom_range(9, 0) < 2);
      step(a, s, e);
      check_both("R3 R4 R5 random");
    end

    // R2 reset again while driving
    @(negedge clk); rst = 1'b1; sen_n = 1'b0;
    @(posedge clk); #2;
    check("R2 reset forces off", dout, 8'h00, drive, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule